// File: doc/BRIEF.md
# Three-Channel LED Blink Controller

This block drives a small set of indicator LEDs through active-low outputs. Each channel is set to dark, steadily lit or blinking. A blinking channel alternates a programmable lit time and dark time. After a programmed number of complete lit phases, it can also insert one longer dark gap before the cycle starts again. Every duration is counted in ticks of a slow time base, nominally 1/16 s, which an internal prescaler derives from the clock.

Software, or a command decoder, loads one channel at a time through a configuration strobe. The strobe carries the mode and four timing fields, and the write restarts that channel's pattern at the start of its lit phase. A status port reports the mode of any channel. A force-off input blanks every LED without losing any setting and holds the blink timing while it is asserted. The pattern then continues from where it stopped. A busy output tells power control that some LED needs the clock to keep running.

Top module: `led_blinker`

## Requirements
- R1: After reset every LED output is high (dark), busy is low and every channel reports mode 0.
- R2: A channel in mode 0 (off) keeps its output high.
- R3: A channel in mode 1 (on) holds its output low while force-off is low.
- R4: A channel in mode 2 (blink) drives its output low for onTime ticks, then high for offTime ticks, and repeats. A write starts the channel with a lit phase that lasts onTime ticks, counted from the first tick after the write. One tick is TICK_DIV clock cycles, and the first tick falls on the TICK_DIV-th clock edge after reset is released.
- R5: When metaCount is non-zero, every metaCount-th lit phase is followed by a dark gap of metaOff ticks instead of offTime, and the lit/dark cycle then resumes. A metaCount of 0 turns the long gap off.
- R6: A timing field of 0 behaves as a duration of 1 tick.
- R7: While forceOff is high, all outputs are high, the blink timing does not advance and settings are kept. When forceOff falls, each channel continues from the phase and remaining time it had.
- R8: busy is high exactly when at least one channel is in mode 1 or 2 and forceOff is low.
- R9: statMode returns the stored mode of the channel that statSel selects, and returns 3 for a select value with no channel. A write whose cfgSel selects no channel changes nothing.
- R10: When a write and a tick fall in the same cycle, the write wins and the lit phase still lasts the full onTime ticks.
- R11: A written mode code of 3 is stored as off, so the channel stays dark and reports 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrite | input | 1 | One-cycle configuration write strobe |
| cfgSel | input | SEL_W | Channel addressed by the write |
| cfgMode | input | 2 | Mode code: 0 off, 1 on, 2 blink |
| cfgOnTime | input | 8 | Lit time in ticks |
| cfgOffTime | input | 8 | Normal dark time in ticks |
| cfgMetaCount | input | 8 | Lit phases before the long gap, 0 disables the gap |
| cfgMetaOff | input | 8 | Long dark gap in ticks |
| forceOff | input | 1 | Blank all LEDs and freeze their timing |
| statSel | input | SEL_W | Channel whose mode is reported |
| statMode | output | 2 | Mode of the selected channel, 3 if no channel |
| ledN | output | NUM_LEDS | Active-low LED drives |
| busy | output | 1 | Some LED is lit or blinking and not forced off |

## Verification
Two pairs of events can fall in the same cycle. A configuration write can land on a prescaler tick, and force-off can be high during a tick. The bench tracks the tick phase and times a write onto the tick edge. It then checks that the new lit phase still lasts its full length. It also holds force-off across several ticks in the middle of a blink and checks that, after release, the pattern picks up with the same remaining time.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  localparam int TIME_W = 8;
  localparam int MAX_SEL_W = 4;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_ON    = 2'd1,
    MODE_BLINK = 2'd2,
    MODE_NONE  = 2'd3
  } led_mode_e;

  typedef enum logic [1:0] {
    PH_LIT  = 2'd0,
    PH_DARK = 2'd1,
    PH_META = 2'd2
  } blink_phase_e;

  typedef struct packed {
    led_mode_e         mode;
    logic [TIME_W-1:0] onTime;
    logic [TIME_W-1:0] offTime;
    logic [TIME_W-1:0] metaCount;
    logic [TIME_W-1:0] metaOff;
  } led_cfg_t;

  typedef struct packed {
    logic                 tickAdv;
    logic                 hold;
    logic                 load;
    logic [MAX_SEL_W-1:0] loadSel;
  } led_strobe_t;
endpackage

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
  import led_blink_pkg::*;
#(
  parameter int TICK_DIV = 125000,
  parameter int NUM_LEDS = 3,
  parameter int SEL_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrite,
  input  logic [SEL_W-1:0]      cfgSel,
  input  logic [1:0]            cfgMode,
  input  logic [TIME_W-1:0]     cfgOnTime,
  input  logic [TIME_W-1:0]     cfgOffTime,
  input  logic [TIME_W-1:0]     cfgMetaCount,
  input  logic [TIME_W-1:0]     cfgMetaOff,
  input  logic                  forceOff,
  input  logic [SEL_W-1:0]      statSel,
  input  logic [2*NUM_LEDS-1:0] modeFlat,
  output led_strobe_t           strobe,
  output led_cfg_t              newCfg,
  output logic [1:0]            statMode,
  output logic                  busy
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CNT_W-1:0] preCnt;
  logic             tick;
  logic             anyActive;

  assign tick = (preCnt == CNT_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= tick ? '0 : preCnt + 1'b1;
  end

  // R11: the unused code 3 is folded to off before storage
  always_comb begin
    newCfg.mode      = (cfgMode == MODE_NONE) ? MODE_OFF : led_mode_e'(cfgMode);
    newCfg.onTime    = cfgOnTime;
    newCfg.offTime   = cfgOffTime;
    newCfg.metaCount = cfgMetaCount;
    newCfg.metaOff   = cfgMetaOff;
  end

  always_comb begin
    strobe.tickAdv = tick & ~forceOff;
    strobe.hold    = forceOff;
    strobe.load    = cfgWrite && (cfgSel < SEL_W'(NUM_LEDS));
    strobe.loadSel = MAX_SEL_W'(cfgSel);
  end

  always_comb begin
    statMode  = MODE_NONE;
    anyActive = 1'b0;
    for (int i = 0; i < NUM_LEDS; i++) begin
      if (statSel == SEL_W'(i)) statMode = modeFlat[2*i +: 2];
      if (modeFlat[2*i +: 2] != MODE_OFF) anyActive = 1'b1;
    end
  end

  assign busy = anyActive & ~forceOff;
endmodule

// File: rtl/led_blink_datapath.sv
module led_blink_datapath
  import led_blink_pkg::*;
#(
  parameter int NUM_LEDS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  led_strobe_t           strobe,
  input  led_cfg_t              newCfg,
  output logic [NUM_LEDS-1:0]   ledN,
  output logic [2*NUM_LEDS-1:0] modeFlat
);
  function automatic logic [TIME_W-1:0] atLeastOne(input logic [TIME_W-1:0] v);
    return (v == '0) ? TIME_W'(1) : v;
  endfunction

  logic [NUM_LEDS-1:0] lit;

  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_chan
    led_cfg_t          cfgQ;
    blink_phase_e      phQ;
    logic [TIME_W-1:0] tmrQ;
    logic [TIME_W-1:0] blinkQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ   <= '0;
        phQ    <= PH_LIT;
        tmrQ   <= TIME_W'(1);
        blinkQ <= '0;
      end else if (strobe.load && strobe.loadSel == MAX_SEL_W'(g)) begin
        cfgQ   <= newCfg;
        phQ    <= PH_LIT;
        tmrQ   <= atLeastOne(newCfg.onTime);
        blinkQ <= '0;
      end else if (strobe.tickAdv && cfgQ.mode == MODE_BLINK) begin
        if (tmrQ > TIME_W'(1)) begin
          tmrQ <= tmrQ - 1'b1;
        end else if (phQ == PH_LIT) begin
          if (cfgQ.metaCount != '0 && (blinkQ + 1'b1) == cfgQ.metaCount) begin
            phQ    <= PH_META;
            tmrQ   <= atLeastOne(cfgQ.metaOff);
            blinkQ <= '0;
          end else begin
            phQ    <= PH_DARK;
            tmrQ   <= atLeastOne(cfgQ.offTime);
            blinkQ <= blinkQ + 1'b1;
          end
        end else begin
          phQ  <= PH_LIT;
          tmrQ <= atLeastOne(cfgQ.onTime);
        end
      end
    end

    assign lit[g] = (cfgQ.mode == MODE_ON) ||
                    (cfgQ.mode == MODE_BLINK && phQ == PH_LIT);
    assign modeFlat[2*g +: 2] = cfgQ.mode;
  end

  assign ledN = ~(lit & {NUM_LEDS{~strobe.hold}});
endmodule

// File: rtl/led_blinker.sv
module led_blinker
  import led_blink_pkg::*;
#(
  parameter int TICK_DIV = 125000,
  parameter int NUM_LEDS = 3,
  localparam int SEL_W   = $clog2(NUM_LEDS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrite,
  input  logic [SEL_W-1:0]    cfgSel,
  input  logic [1:0]          cfgMode,
  input  logic [7:0]          cfgOnTime,
  input  logic [7:0]          cfgOffTime,
  input  logic [7:0]          cfgMetaCount,
  input  logic [7:0]          cfgMetaOff,
  input  logic                forceOff,
  input  logic [SEL_W-1:0]    statSel,
  output logic [1:0]          statMode,
  output logic [NUM_LEDS-1:0] ledN,
  output logic                busy
);
  led_strobe_t           strobe;
  led_cfg_t              newCfg;
  logic [2*NUM_LEDS-1:0] modeFlat;

  led_blink_ctrl #(.TICK_DIV(TICK_DIV), .NUM_LEDS(NUM_LEDS), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgSel(cfgSel), .cfgMode(cfgMode),
    .cfgOnTime(cfgOnTime), .cfgOffTime(cfgOffTime), .cfgMetaCount(cfgMetaCount),
    .cfgMetaOff(cfgMetaOff), .forceOff(forceOff), .statSel(statSel),
    .modeFlat(modeFlat), .strobe(strobe), .newCfg(newCfg),
    .statMode(statMode), .busy(busy)
  );

  led_blink_datapath #(.NUM_LEDS(NUM_LEDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .newCfg(newCfg),
    .ledN(ledN), .modeFlat(modeFlat)
  );
endmodule

// File: rtl/led_blinker_chk.sv
module led_blinker_chk #(
  parameter int NUM_LEDS = 3,
  parameter int SEL_W    = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  forceOff,
  input logic                  cfgWrite,
  input logic [SEL_W-1:0]      cfgSel,
  input logic [1:0]            cfgMode,
  input logic [SEL_W-1:0]      statSel,
  input logic [1:0]            statMode,
  input logic [NUM_LEDS-1:0]   ledN,
  input logic                  busy,
  input logic [2*NUM_LEDS-1:0] modeFlat
);
  p_force_dark_r7: assert property (@(posedge clk) disable iff (!rstN)
    forceOff |-> (&ledN));

  p_lit_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(&ledN) |-> busy);

  p_idle_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeFlat == '0) |-> !busy);

  p_no_chan_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statSel >= SEL_W'(NUM_LEDS)) |-> (statMode == 2'd3));

  p_write_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgSel < SEL_W'(NUM_LEDS) && cfgSel == statSel) |=>
      ((statSel != $past(statSel)) ||
       (statMode == (($past(cfgMode) == 2'd3) ? 2'd0 : $past(cfgMode)))));

  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_chk
    p_off_dark_r2: assert property (@(posedge clk) disable iff (!rstN)
      (modeFlat[2*g +: 2] == 2'd0) |-> ledN[g]);

    p_steady_on_r3: assert property (@(posedge clk) disable iff (!rstN)
      (modeFlat[2*g +: 2] == 2'd1 && !forceOff) |-> !ledN[g]);

    p_mode_clean_r11: assert property (@(posedge clk) disable iff (!rstN)
      modeFlat[2*g +: 2] != 2'd3);
  end
endmodule

bind led_blinker led_blinker_chk #(.NUM_LEDS(NUM_LEDS), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .forceOff(forceOff), .cfgWrite(cfgWrite), .cfgSel(cfgSel),
  .cfgMode(cfgMode), .statSel(statSel), .statMode(statMode), .ledN(ledN),
  .busy(busy), .modeFlat(modeFlat)
);

// File: tb/led_blinker_tb.sv
module led_blinker_tb;
  localparam int DIV = 4;
  localparam int NL  = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [1:0] cfgMode = '0;
  logic [7:0] cfgOnTime = '0, cfgOffTime = '0, cfgMetaCount = '0, cfgMetaOff = '0;
  logic       forceOff = 1'b0;
  logic [1:0] statSel = '0;
  logic [1:0] statMode;
  logic [NL-1:0] ledN;
  logic       busy;

  always #5 clk = ~clk;

  led_blinker #(.TICK_DIV(DIV), .NUM_LEDS(NL)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgSel(cfgSel), .cfgMode(cfgMode),
    .cfgOnTime(cfgOnTime), .cfgOffTime(cfgOffTime), .cfgMetaCount(cfgMetaCount),
    .cfgMetaOff(cfgMetaOff), .forceOff(forceOff), .statSel(statSel),
    .statMode(statMode), .ledN(ledN), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;

  // reference model built from the requirements
  int mMode[NL], mOn[NL], mOff[NL], mMc[NL], mMo[NL], mPh[NL], mTmr[NL], mBlk[NL];
  bit wt[NL];
  int mCnt = 0;

  typedef struct { logic [NL-1:0] led; logic bz; int tag[NL]; } exp_t;
  exp_t sbq[$];

  function automatic int one(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic string tagName(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   10: return "R10";
      default: return "R?";
    endcase
  endfunction

  always @(posedge clk) begin
    exp_t e;
    bit tk;
    bit anyAct;
    if (!rstN) begin
      mCnt = 0;
      for (int i = 0; i < NL; i++) begin
        mMode[i] = 0; mOn[i] = 0; mOff[i] = 0; mMc[i] = 0; mMo[i] = 0;
        mPh[i] = 0; mTmr[i] = 1; mBlk[i] = 0; wt[i] = 0;
      end
    end else begin
      tk = (mCnt == DIV - 1);
      mCnt = tk ? 0 : mCnt + 1;
      for (int i = 0; i < NL; i++) begin
        if (cfgWrite && int'(cfgSel) == i) begin
          mMode[i] = (cfgMode == 2'd3) ? 0 : int'(cfgMode);
          mOn[i] = cfgOnTime; mOff[i] = cfgOffTime; mMc[i] = cfgMetaCount; mMo[i] = cfgMetaOff;
          mPh[i] = 0; mTmr[i] = one(mOn[i]); mBlk[i] = 0;
          wt[i] = tk && (mMode[i] == 2);
        end else if (tk && !forceOff && mMode[i] == 2) begin
          if (mTmr[i] > 1) mTmr[i]--;
          else begin
            wt[i] = 0;
            if (mPh[i] == 0) begin
              if (mMc[i] != 0 && mBlk[i] + 1 == mMc[i]) begin
                mPh[i] = 2; mTmr[i] = one(mMo[i]); mBlk[i] = 0;
              end else begin
                mPh[i] = 1; mTmr[i] = one(mOff[i]); mBlk[i]++;
              end
            end else begin
              mPh[i] = 0; mTmr[i] = one(mOn[i]);
            end
          end
        end
      end
    end
    anyAct = 0;
    for (int i = 0; i < NL; i++) begin
      bit lt;
      lt = (mMode[i] == 1) || (mMode[i] == 2 && mPh[i] == 0);
      e.led[i] = !(lt && !forceOff && rstN);
      if (mMode[i] != 0) anyAct = 1;
      if (!rstN) e.tag[i] = 1;
      else if (forceOff) e.tag[i] = 7;
      else if (mMode[i] == 0) e.tag[i] = 2;
      else if (mMode[i] == 1) e.tag[i] = 3;
      else if (wt[i]) e.tag[i] = 10;
      else if (mOn[i] == 0 || mOff[i] == 0 || (mMc[i] != 0 && mMo[i] == 0)) e.tag[i] = 6;
      else if (mMc[i] != 0) e.tag[i] = 5;
      else e.tag[i] = 4;
    end
    e.bz = anyAct && !forceOff && rstN;
    sbq.push_back(e);
  end

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      for (int i = 0; i < NL; i++) begin
        checks++;
        if (ledN[i] !== e.led[i]) begin
          fails++;
          $display("FAIL %s led%0d actual=%b expected=%b t=%0t", tagName(e.tag[i]), i, ledN[i], e.led[i], $time);
        end
      end
      checks++;
      if (busy !== e.bz) begin
        fails++;
        $display("FAIL R8 busy actual=%b expected=%b t=%0t", busy, e.bz, $time);
      end
    end
  end

  task automatic wrCfg(input int sel, input int mode, input int on, input int off, input int mc, input int mo);
    @(negedge clk); #1;
    cfgWrite = 1'b1; cfgSel = 2'(sel); cfgMode = 2'(mode);
    cfgOnTime = 8'(on); cfgOffTime = 8'(off); cfgMetaCount = 8'(mc); cfgMetaOff = 8'(mo);
    @(negedge clk); #1;
    cfgWrite = 1'b0;
  endtask

  task automatic chkStat(input int sel, input int exp, input string tag);
    @(negedge clk); #1;
    statSel = 2'(sel);
    @(negedge clk);
    checks++;
    if (statMode !== 2'(exp)) begin
      fails++;
      $display("FAIL %s statMode sel=%0d actual=%0d expected=%0d", tag, sel, statMode, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    for (int i = 0; i < NL; i++) chkStat(i, 0, "R1");
    // R3 steady on, R5 meta gap, R6 zero intervals
    wrCfg(0, 1, 0, 0, 0, 0);
    wrCfg(1, 2, 2, 3, 2, 6);
    wrCfg(2, 2, 0, 0, 0, 0);
    chkStat(0, 1, "R3");
    chkStat(1, 2, "R4");
    idle(200);
    // R4 plain blink without meta gap
    wrCfg(2, 2, 3, 1, 0, 9);
    idle(120);
    // R7: freeze mid-blink, then resume
    @(negedge clk); #1 forceOff = 1'b1;
    idle(23);
    @(negedge clk); #1 forceOff = 1'b0;
    idle(80);
    // R10: write on the tick edge
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      while (mCnt != DIV - 1) begin @(negedge clk); #1; end
      cfgWrite = 1'b1; cfgSel = 2'(k % 2 + 1); cfgMode = 2'd2;
      cfgOnTime = 8'(2 + k); cfgOffTime = 8'd2; cfgMetaCount = 8'(k); cfgMetaOff = 8'd4;
      @(negedge clk); #1 cfgWrite = 1'b0;
      idle(40);
    end
    // R11: mode code 3 stored as off
    wrCfg(1, 3, 1, 1, 0, 0);
    chkStat(1, 0, "R11");
    idle(20);
    // R9: select 3 reads 3 and a write to it is ignored
    chkStat(3, 3, "R9");
    wrCfg(3, 1, 5, 5, 0, 0);
    chkStat(0, 1, "R9");
    chkStat(1, 0, "R9");
    chkStat(2, 2, "R9");
    // R2 and R8: all off gives busy low
    wrCfg(0, 0, 0, 0, 0, 0);
    wrCfg(2, 0, 0, 0, 0, 0);
    chkStat(2, 0, "R2");
    idle(20);
    // mixed patterns with meta gaps of several lengths
    for (int k = 1; k < 6; k++) begin
      wrCfg(k % NL, 2, k, 6 - k, k % 3, k + 1);
      idle(60);
      if (k == 3) begin
        @(negedge clk); #1 forceOff = 1'b1;
        idle(9);
        @(negedge clk); #1 forceOff = 1'b0;
      end
    end
    idle(100);
    finishRun();
  end
endmodule